// File: doc/BRIEF.md
# MII Loopback and Test Controller

This block sits between a MAC core and the external MII nibble pins. It carries the diagnostic controls of the port. In internal loopback it feeds the MAC's transmit nibbles back into the MAC's receive inputs inside the chip. In external loopback and in normal operation it passes the receive side through from the PHY. The MDC/MDIO management wires always pass straight through.

Every output is registered, so each path has one clock of latency. Either loopback mode forces the MAC to accept runt frames. A test mode can force a collision on every transmit attempt made in internal loopback. An attempt counter then raises a one-cycle retry error when the sixteenth collided attempt begins.

Mode requests are sampled only while the MAC's transmit enable is low. A frame in flight therefore never changes route partway through.

Top module: `mii_loop_ctrl`

## Requirements
- R1: While internal loopback is in effect, `mac_rxd` and `mac_rx_dv` equal the `mac_txd` and `mac_tx_en` that were present one clock earlier.
- R2: In every mode, `phy_txd` and `phy_tx_en` equal `mac_txd` and `mac_tx_en` from one clock earlier, so the transmit pins stay active during internal loopback.
- R3: In every mode, `phy_mdc`, `phy_mdio_o` and `phy_mdio_oe` equal the MAC's management outputs from one clock earlier, and `mac_mdio_i` equals `phy_mdio_i` from one clock earlier.
- R4: While internal loopback is in effect, `phy_rxd`, `phy_rx_dv`, `phy_crs` and `phy_col` have no effect on the MAC side. `mac_crs` equals `mac_tx_en` from one clock earlier.
- R5: In normal mode and in external loopback, `mac_rxd`, `mac_rx_dv`, `mac_crs` and `mac_col` equal the PHY receive pins from one clock earlier.
- R6: `mac_runt_acc` is 1 whenever a loopback mode is in effect, and in that case the runt-accept bit has no effect. In normal mode `mac_runt_acc` follows `cfg_runt_acc`, one clock later.
- R7: When both loopback bits are set, internal loopback is the mode that takes effect.
- R8: When force-collision and internal loopback are both in effect, `mac_col` is 1 on each clock that follows a clock with `mac_tx_en` high. Outside internal loopback the force-collision bit has no effect on `mac_col`.
- R9: In the forced-collision test, every rising edge of `mac_tx_en` counts as one collided attempt. `mac_retry_err` pulses high for exactly one clock, together with `mac_col`, when the 16th attempt starts. The count then restarts at zero, and it also clears whenever the test mode is left.
- R10: A change to the loopback or force-collision bits takes effect only at a clock edge where `mac_tx_en` is low. Data-path outputs follow the new mode from the next clock on.
- R11: A synchronous active-high `rst` drives every output to 0 and selects normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_int_lb | input | 1 | Request internal loopback |
| cfg_ext_lb | input | 1 | Request external loopback |
| cfg_force_col | input | 1 | Force a collision on each attempt in internal loopback |
| cfg_runt_acc | input | 1 | Runt-accept policy for normal mode |
| mac_txd | input | 4 | Transmit nibble from the MAC |
| mac_tx_en | input | 1 | Transmit enable from the MAC |
| mac_rxd | output | 4 | Receive nibble to the MAC |
| mac_rx_dv | output | 1 | Receive data valid to the MAC |
| mac_crs | output | 1 | Carrier sense to the MAC |
| mac_col | output | 1 | Collision to the MAC |
| mac_runt_acc | output | 1 | Effective runt-accept to the MAC |
| mac_retry_err | output | 1 | One-cycle pulse after 16 forced collided attempts |
| mac_mdc | input | 1 | Management clock from the MAC |
| mac_mdio_o | input | 1 | Management data out from the MAC |
| mac_mdio_oe | input | 1 | Management output enable from the MAC |
| mac_mdio_i | output | 1 | Management data in to the MAC |
| phy_txd | output | 4 | Transmit nibble pins |
| phy_tx_en | output | 1 | Transmit enable pin |
| phy_rxd | input | 4 | Receive nibble pins |
| phy_rx_dv | input | 1 | Receive data valid pin |
| phy_crs | input | 1 | Carrier sense pin |
| phy_col | input | 1 | Collision pin |
| phy_mdc | output | 1 | Management clock pin |
| phy_mdio_o | output | 1 | Management data out pin |
| phy_mdio_oe | output | 1 | Management output enable pin |
| phy_mdio_i | input | 1 | Management data in pin |

## Verification
The forced collision and the retry error share one clock. The start of the sixteenth attempt both raises `mac_col` and ends the attempt count. The bench provokes this by opening sixteen short transmit bursts in the forced-collision test. It judges the clock after each rising `mac_tx_en`: `mac_col` must be high on every one of them, and `mac_retry_err` only on the sixteenth. A second meeting is a loopback request that arrives in the middle of a frame. The bench expects the old route to hold until `mac_tx_en` falls, and the looped route on the second clock after that.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_INT  = 2'd1,
    MODE_EXT  = 2'd2
  } lb_mode_t;
endpackage

// File: rtl/mlc_mode_ctrl.sv
module mlc_mode_ctrl
  import mlc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tx_en,
  input  logic     req_int,
  input  logic     req_ext,
  input  logic     req_fc,
  output lb_mode_t mode_o,
  output logic     fc_o
);
  lb_mode_t mode_q;
  lb_mode_t mode_d;
  logic     fc_q;

  // internal loopback wins when both are requested
  always_comb begin
    if (req_int)      mode_d = MODE_INT;
    else if (req_ext) mode_d = MODE_EXT;
    else              mode_d = MODE_NORM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_NORM;
      fc_q   <= 1'b0;
    end else if (!tx_en) begin
      mode_q <= mode_d;
      fc_q   <= req_fc;
    end
  end

  assign mode_o = mode_q;
  assign fc_o   = fc_q;
endmodule

// File: rtl/mlc_data_path.sv
module mlc_data_path
  import mlc_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  lb_mode_t          mode,
  input  logic              fc,
  input  logic [DATA_W-1:0] m_txd,
  input  logic              m_tx_en,
  input  logic [DATA_W-1:0] p_rxd,
  input  logic              p_rx_dv,
  input  logic              p_crs,
  input  logic              p_col,
  output logic [DATA_W-1:0] m_rxd,
  output logic              m_rx_dv,
  output logic              m_crs,
  output logic              m_col,
  output logic [DATA_W-1:0] p_txd,
  output logic              p_tx_en
);
  logic [DATA_W-1:0] rxd_d;
  logic              dv_d, crs_d, col_d;

  always_comb begin
    if (mode == MODE_INT) begin
      rxd_d = m_txd;
      dv_d  = m_tx_en;
      crs_d = m_tx_en;
      col_d = fc & m_tx_en;
    end else begin
      rxd_d = p_rxd;
      dv_d  = p_rx_dv;
      crs_d = p_crs;
      col_d = p_col;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_rxd   <= '0;
      m_rx_dv <= 1'b0;
      m_crs   <= 1'b0;
      m_col   <= 1'b0;
      p_txd   <= '0;
      p_tx_en <= 1'b0;
    end else begin
      m_rxd   <= rxd_d;
      m_rx_dv <= dv_d;
      m_crs   <= crs_d;
      m_col   <= col_d;
      p_txd   <= m_txd;
      p_tx_en <= m_tx_en;
    end
  end
endmodule

// File: rtl/mlc_retry_mon.sv
module mlc_retry_mon #(
  parameter int MAX_ATTEMPTS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic test_en,
  input  logic tx_en,
  output logic retry_err
);
  localparam int CW = (MAX_ATTEMPTS > 2) ? $clog2(MAX_ATTEMPTS) : 1;
  localparam logic [CW-1:0] LAST = CW'(MAX_ATTEMPTS - 1);

  logic [CW-1:0] cnt_q;
  logic          txen_q;
  logic          start;

  assign start = tx_en & ~txen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      txen_q    <= 1'b0;
      retry_err <= 1'b0;
    end else begin
      txen_q    <= tx_en;
      retry_err <= 1'b0;
      if (!test_en) begin
        cnt_q <= '0;
      end else if (start) begin
        if (cnt_q == LAST) begin
          cnt_q     <= '0;
          retry_err <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mii_loop_ctrl.sv
module mii_loop_ctrl
  import mlc_pkg::*;
#(
  parameter int DATA_W       = 4,
  parameter int MAX_ATTEMPTS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_int_lb,
  input  logic              cfg_ext_lb,
  input  logic              cfg_force_col,
  input  logic              cfg_runt_acc,
  input  logic [DATA_W-1:0] mac_txd,
  input  logic              mac_tx_en,
  output logic [DATA_W-1:0] mac_rxd,
  output logic              mac_rx_dv,
  output logic              mac_crs,
  output logic              mac_col,
  output logic              mac_runt_acc,
  output logic              mac_retry_err,
  input  logic              mac_mdc,
  input  logic              mac_mdio_o,
  input  logic              mac_mdio_oe,
  output logic              mac_mdio_i,
  output logic [DATA_W-1:0] phy_txd,
  output logic              phy_tx_en,
  input  logic [DATA_W-1:0] phy_rxd,
  input  logic              phy_rx_dv,
  input  logic              phy_crs,
  input  logic              phy_col,
  output logic              phy_mdc,
  output logic              phy_mdio_o,
  output logic              phy_mdio_oe,
  input  logic              phy_mdio_i
);
  lb_mode_t mode;
  logic     fc;

  mlc_mode_ctrl u_mode (
    .clk    (clk),
    .rst    (rst),
    .tx_en  (mac_tx_en),
    .req_int(cfg_int_lb),
    .req_ext(cfg_ext_lb),
    .req_fc (cfg_force_col),
    .mode_o (mode),
    .fc_o   (fc)
  );

  mlc_data_path #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .fc     (fc),
    .m_txd  (mac_txd),
    .m_tx_en(mac_tx_en),
    .p_rxd  (phy_rxd),
    .p_rx_dv(phy_rx_dv),
    .p_crs  (phy_crs),
    .p_col  (phy_col),
    .m_rxd  (mac_rxd),
    .m_rx_dv(mac_rx_dv),
    .m_crs  (mac_crs),
    .m_col  (mac_col),
    .p_txd  (phy_txd),
    .p_tx_en(phy_tx_en)
  );

  mlc_retry_mon #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_retry (
    .clk      (clk),
    .rst      (rst),
    .test_en  ((mode == MODE_INT) && fc),
    .tx_en    (mac_tx_en),
    .retry_err(mac_retry_err)
  );

  // management wires and runt policy
  always_ff @(posedge clk) begin
    if (rst) begin
      phy_mdc      <= 1'b0;
      phy_mdio_o   <= 1'b0;
      phy_mdio_oe  <= 1'b0;
      mac_mdio_i   <= 1'b0;
      mac_runt_acc <= 1'b0;
    end else begin
      phy_mdc      <= mac_mdc;
      phy_mdio_o   <= mac_mdio_o;
      phy_mdio_oe  <= mac_mdio_oe;
      mac_mdio_i   <= phy_mdio_i;
      mac_runt_acc <= cfg_runt_acc | (mode != MODE_NORM);
    end
  end
endmodule

// File: rtl/mii_loop_ctrl_chk.sv
module mii_loop_ctrl_chk
  import mlc_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input lb_mode_t          mode,
  input logic [DATA_W-1:0] mac_txd,
  input logic              mac_tx_en,
  input logic [DATA_W-1:0] mac_rxd,
  input logic              mac_rx_dv,
  input logic              mac_col,
  input logic              mac_runt_acc,
  input logic              mac_retry_err,
  input logic              mac_mdc,
  input logic [DATA_W-1:0] phy_txd,
  input logic              phy_tx_en,
  input logic              phy_mdc
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r1_int_loop: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(mode == MODE_INT) |-> (mac_rx_dv == $past(mac_tx_en) && mac_rxd == $past(mac_txd)));

  a_r2_tx_pins: assert property (@(posedge clk) disable iff (rst || !past_ok)
    phy_tx_en == $past(mac_tx_en) && phy_txd == $past(mac_txd));

  a_r3_mdc_pass: assert property (@(posedge clk) disable iff (rst || !past_ok)
    phy_mdc == $past(mac_mdc));

  a_r6_runt_forced: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(mode != MODE_NORM) |-> mac_runt_acc);

  a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
    mac_retry_err |=> !mac_retry_err);

  a_r9_err_with_col: assert property (@(posedge clk) disable iff (rst)
    mac_retry_err |-> mac_col);

  a_r10_mode_hold: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$stable(mode) |-> !$past(mac_tx_en));
endmodule

bind mii_loop_ctrl mii_loop_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode         (mode),
  .mac_txd      (mac_txd),
  .mac_tx_en    (mac_tx_en),
  .mac_rxd      (mac_rxd),
  .mac_rx_dv    (mac_rx_dv),
  .mac_col      (mac_col),
  .mac_runt_acc (mac_runt_acc),
  .mac_retry_err(mac_retry_err),
  .mac_mdc      (mac_mdc),
  .phy_txd      (phy_txd),
  .phy_tx_en    (phy_tx_en),
  .phy_mdc      (phy_mdc)
);

// File: tb/sim_mii_loop_ctrl.sv
`timescale 1ns/1ps
module sim_mii_loop_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_int_lb = 0, cfg_ext_lb = 0, cfg_force_col = 0, cfg_runt_acc = 0;
  logic [3:0] mac_txd = '0;
  logic mac_tx_en = 0;
  logic [3:0] mac_rxd;
  logic mac_rx_dv, mac_crs, mac_col, mac_runt_acc, mac_retry_err;
  logic mac_mdc = 0, mac_mdio_o = 0, mac_mdio_oe = 0;
  logic mac_mdio_i;
  logic [3:0] phy_txd;
  logic phy_tx_en;
  logic [3:0] phy_rxd = '0;
  logic phy_rx_dv = 0, phy_crs = 0, phy_col = 0;
  logic phy_mdc, phy_mdio_o, phy_mdio_oe;
  logic phy_mdio_i = 0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mii_loop_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic i, input logic e, input logic f);
    mac_tx_en = 0;
    cfg_int_lb = i; cfg_ext_lb = e; cfg_force_col = f;
    step(2);
  endtask

  task automatic t_reset();
    rst = 1; step(3);
    chk("R11 rx_dv", mac_rx_dv, 0);
    chk("R11 rxd", mac_rxd, 0);
    chk("R11 tx_en", phy_tx_en, 0);
    chk("R11 retry", mac_retry_err, 0);
    chk("R11 runt", mac_runt_acc, 0);
    rst = 0; step(1);
  endtask

  task automatic t_normal();
    set_mode(0, 0, 0);
    cfg_runt_acc = 0;
    phy_rxd = 4'h6; phy_rx_dv = 1; phy_crs = 1; phy_col = 1;
    mac_txd = 4'h3; mac_tx_en = 1;
    step(1);
    chk("R5 norm rxd", mac_rxd, 4'h6);
    chk("R5 norm dv/crs/col", {mac_rx_dv, mac_crs, mac_col}, 3'b111);
    chk("R2 norm txd", {phy_tx_en, phy_txd}, {1'b1, 4'h3});
    chk("R6 norm runt off", mac_runt_acc, 0);
    cfg_runt_acc = 1; step(1);
    chk("R6 norm runt on", mac_runt_acc, 1);
    cfg_runt_acc = 0; mac_tx_en = 0; phy_col = 0; step(1);
  endtask

  task automatic t_int_lb();
    set_mode(1, 0, 0);
    phy_rxd = 4'h9; phy_rx_dv = 1; phy_crs = 1; phy_col = 1;
    for (int k = 0; k < 4; k++) begin
      mac_txd = 4'(k + 4'hA); mac_tx_en = 1;
      step(1);
      chk("R1 int rxd", mac_rxd, 4'(k + 4'hA));
      chk("R1 int dv", mac_rx_dv, 1);
      chk("R2 int tx pins", {phy_tx_en, phy_txd}, {1'b1, 4'(k + 4'hA)});
      chk("R4 int crs/col", {mac_crs, mac_col}, 2'b10);
    end
    mac_tx_en = 0; step(1);
    chk("R4 int crs idle", {mac_rx_dv, mac_crs}, 2'b00);
    chk("R6 int runt forced", mac_runt_acc, 1);
  endtask

  task automatic t_ext_lb();
    set_mode(0, 1, 1);
    phy_rxd = 4'h5; phy_rx_dv = 1; phy_crs = 0; phy_col = 0;
    mac_txd = 4'hC; mac_tx_en = 1;
    step(1);
    chk("R5 ext rxd", mac_rxd, 4'h5);
    chk("R8 ext fc ignored", mac_col, 0);
    chk("R6 ext runt forced", mac_runt_acc, 1);
    chk("R2 ext tx pins", phy_txd, 4'hC);
    mac_tx_en = 0; step(1);
  endtask

  task automatic t_priority();
    set_mode(1, 1, 0);
    phy_rxd = 4'h1; phy_rx_dv = 0;
    mac_txd = 4'hE; mac_tx_en = 1;
    step(1);
    chk("R7 both bits -> internal", {mac_rx_dv, mac_rxd}, {1'b1, 4'hE});
    mac_tx_en = 0; step(1);
  endtask

  task automatic t_defer();
    set_mode(0, 0, 0);
    phy_rxd = 4'h5; phy_rx_dv = 1; phy_crs = 1;
    mac_txd = 4'hA; mac_tx_en = 1;
    step(1);
    cfg_int_lb = 1;
    step(3);
    chk("R10 held mid-frame", mac_rxd, 4'h5);
    mac_tx_en = 0;
    step(1);
    chk("R10 still old on first idle", mac_rxd, 4'h5);
    step(1);
    chk("R10 new mode rxd", mac_rxd, 4'hA);
    chk("R10 new mode crs", {mac_rx_dv, mac_crs}, 2'b00);
  endtask

  task automatic t_retry();
    set_mode(1, 0, 1);
    phy_col = 0;
    for (int a = 1; a <= 16; a++) begin
      mac_tx_en = 1; mac_txd = 4'h7;
      step(1);
      chk("R8 forced col", mac_col, 1);
      chk("R9 retry at start", mac_retry_err, (a == 16));
      step(1);
      chk("R9 retry one cycle", mac_retry_err, 0);
      chk("R8 col held", mac_col, 1);
      mac_tx_en = 0; step(2);
      chk("R8 col idle", mac_col, 0);
    end
    // counter restarted: 15 more attempts give no error
    for (int a = 1; a <= 15; a++) begin
      mac_tx_en = 1; step(1);
      chk("R9 restart no err", mac_retry_err, 0);
      mac_tx_en = 0; step(1);
    end
    // leave test mode: clears count; re-enter, one attempt gives no error
    set_mode(1, 0, 0);
    set_mode(1, 0, 1);
    mac_tx_en = 1; step(1);
    chk("R9 cleared on leave", mac_retry_err, 0);
    mac_tx_en = 0; step(1);
  endtask

  task automatic t_mgmt();
    for (int m = 0; m < 3; m++) begin
      set_mode(m == 1, m == 2, 0);
      mac_mdc = 1; mac_mdio_o = 0; mac_mdio_oe = 1; phy_mdio_i = 1;
      step(1);
      chk("R3 mgmt out", {phy_mdc, phy_mdio_o, phy_mdio_oe}, 3'b101);
      chk("R3 mgmt in", mac_mdio_i, 1);
      mac_mdc = 0; mac_mdio_o = 1; mac_mdio_oe = 0; phy_mdio_i = 0;
      step(1);
      chk("R3 mgmt out2", {phy_mdc, phy_mdio_o, phy_mdio_oe}, 3'b010);
      chk("R3 mgmt in2", mac_mdio_i, 0);
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_normal();
        t_int_lb();
        t_ext_lb();
        t_priority();
        t_defer();
        t_retry();
        t_mgmt();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=timeout expected=done");
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule